// File: doc/BRIEF.md
# Time-Shared FIR Filter with Output-Slot Watermark

This block is an eight-tap FIR filter built around one shared multiplier. It takes one input sample per processing period of eight clock cycles and reports one filtered result per period. The result appears on the single data output in the last cycle of the period, qualified by a one-cycle valid flag. A small step counter sequences the shared datapath. A pair adder and an accumulator collect the products.

In the seven cycles where the valid flag is low, the output port is otherwise unused. The block fills four of those cycles with chosen internal values of the computation: a single product and two partial pair sums, at fixed steps. The output therefore carries an ownership signature. The owner can confirm it by applying known inputs and comparing those cycles against the expected relations. Marking changes neither the latency nor the valid results. A parameter turns marking off, and the output then holds the last result in every free cycle.

Step k denotes the cycle number counted from reset release, modulo 8. Sample x0 is the most recently captured input sample and xi the sample captured i periods earlier; both are zero if no such capture has happened since reset. Coefficient hk sits in bits [16k+15:16k] of the coefficient parameter.

Top module: `wm_fir`

## Requirements
- R1: A synchronous active-high reset clears the sample history, all partial results and the step counter. In the first cycle after release, out_data is 0 and out_valid is 0, and every output of the first period is 0.
- R2: out_valid is high in step 7 only: exactly one cycle in every eight, and first in the eighth cycle after reset release.
- R3: in_sample is captured only at the clock edge that ends a step-7 cycle. Its value in any other cycle has no effect on any later output.
- R4: In step 7, out_data shows the filter result Y = sum over i = 0..7 of xi*h(7-i), computed over the samples captured before that cycle.
- R5: Every value V shown on out_data is the 35-bit two's-complement value sign-extended and shifted arithmetically right by 15, of which the low 16 bits are kept. Results and marks follow the same rule.
- R6: With marking on, step 1 shows x2*h5.
- R7: With marking on, step 3 shows x0*h7 + x1*h6.
- R8: With marking on, step 5 shows x6*h1 + x7*h0.
- R9: With marking on, step 6 again shows x2*h5, the same value as in step 1 of that period.
- R10: With marking on, steps 0, 2 and 4 show the most recent step-7 result, or 0 if no period has completed since reset.
- R11: With marking off (MARK_EN = 0), every step other than 7 shows the most recent step-7 result. The step-7 results match those of the marked build exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_sample | input | 16 | Signed input sample, taken at the end of step 7 |
| out_data | output | 16 | Filter result in step 7, watermark value or held result otherwise |
| out_valid | output | 1 | High in step 7 while out_data carries the filter result |

## Verification
Two functions share step 7. The valid result is on the output while the shared multiplier already consumes the next input sample from the port and the sample line shifts. The bench drives extreme samples in exactly that cycle and random values in every other cycle, then compares the same-cycle result and the next period's marks against a behavioural model. A second collision is the reuse of one product register for the step-1 and step-6 marks while the pair and accumulator registers move underneath. This is judged on every period with impulse, full-scale positive, full-scale negative and random inputs, on a marked and an unmarked instance side by side, and across a reset applied in mid-period.

// File: rtl/wmfir_pkg.sv
package wmfir_pkg;

    localparam int STEPS = 8;

    typedef logic [2:0] step_t;

    // Step numbers whose behaviour is observed at the output.
    localparam step_t ST_MK1 = 3'd1;
    localparam step_t ST_MK2 = 3'd3;
    localparam step_t ST_MK3 = 3'd5;
    localparam step_t ST_MK4 = 3'd6;
    localparam step_t ST_SUM = 3'd6;
    localparam step_t ST_RES = 3'd7;

    // Tap handled by the shared multiplier in each step (tap i = xi*h(7-i)).
    // Tap 0 is taken straight from the input port in the last step.
    function automatic logic [2:0] sched_tap(step_t s);
        logic [2:0] t;
        case (s)
            3'd0:    t = 3'd2;
            3'd1:    t = 3'd1;
            3'd2:    t = 3'd3;
            3'd3:    t = 3'd6;
            3'd4:    t = 3'd7;
            3'd5:    t = 3'd4;
            3'd6:    t = 3'd5;
            default: t = 3'd0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/wmfir_line.sv
module wmfir_line #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift,
    input  logic [DATA_W-1:0]       din,
    output logic [DEPTH*DATA_W-1:0] taps_flat
);

    logic [DATA_W-1:0] stage_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic [DATA_W-1:0] stage_d;
        if (g == 0) begin : g_head
            assign stage_d = shift ? din : stage_q[0];
        end else begin : g_body
            assign stage_d = shift ? stage_q[g-1] : stage_q[g];
        end
        always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= '0;
            else     stage_q[g] <= stage_d;
        end
        assign taps_flat[g*DATA_W +: DATA_W] = stage_q[g];
    end

    AST_LINE_STILL: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(taps_flat)); // R3

endmodule

// File: rtl/wmfir_coef.sv
module wmfir_coef #(
    parameter int                  COEF_W = 16,
    parameter int                  NCOEF  = 8,
    parameter logic [NCOEF*COEF_W-1:0] COEFS = '0
) (
    input  logic [$clog2(NCOEF)-1:0] idx,
    output logic [COEF_W-1:0]        coef
);

    logic [COEF_W-1:0] rom [NCOEF];

    for (genvar g = 0; g < NCOEF; g++) begin : g_rom
        assign rom[g] = COEFS[g*COEF_W +: COEF_W];
    end

    assign coef = rom[idx];

endmodule

// File: rtl/wmfir_outsel.sv
module wmfir_outsel
    import wmfir_pkg::*;
#(
    parameter int ACC_W     = 35,
    parameter int OUT_W     = 16,
    parameter int OUT_SHIFT = 15,
    parameter bit MARK_EN   = 1'b1
) (
    input  step_t                    step,
    input  logic signed [ACC_W-1:0]  y,
    input  logic signed [ACC_W-1:0]  keep,
    input  logic signed [ACC_W-1:0]  pair,
    output logic [OUT_W-1:0]         data,
    output logic                     valid
);

    logic signed [ACC_W-1:0] pick;

    if (MARK_EN) begin : g_mark
        always_comb begin
            case (step)
                ST_MK1, ST_MK4: pick = keep;
                ST_MK2, ST_MK3: pick = pair;
                default:        pick = y;
            endcase
        end
    end else begin : g_plain
        assign pick = y;
    end

    assign data  = OUT_W'(pick >>> OUT_SHIFT);
    assign valid = (step == ST_RES);

endmodule

// File: rtl/wm_fir.sv
module wm_fir
    import wmfir_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int COEF_W    = 16,
    parameter int ACC_W     = 35,
    parameter int OUT_W     = 16,
    parameter int OUT_SHIFT = 15,
    parameter bit MARK_EN   = 1'b1,
    parameter logic [8*COEF_W-1:0] COEFS = {
        -16'sd777, 16'sd2468, -16'sd4321, 16'sd11111,
        16'sd12000, 16'sd5230, -16'sd3100, 16'sd1200}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_sample,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_valid
);

    localparam int TAPS   = STEPS;
    localparam int IDX_W  = $clog2(TAPS);
    localparam int PROD_W = DATA_W + COEF_W;

    typedef struct packed {
        step_t                   step;
        logic signed [ACC_W-1:0] keep;
        logic signed [ACC_W-1:0] pair;
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] y;
    } st_t;

    st_t st_d, st_q;

    logic [TAPS*DATA_W-1:0]   line_flat;
    logic [IDX_W-1:0]         tsel;
    logic [IDX_W-1:0]         cidx;
    logic [COEF_W-1:0]        coef_raw;
    logic signed [DATA_W-1:0] smp;
    logic signed [COEF_W-1:0] cf;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  mulx;
    logic                     shift;

    assign shift = (st_q.step == ST_RES);

    wmfir_line #(.DATA_W(DATA_W), .DEPTH(TAPS)) u_line (
        .clk      (clk),
        .rst      (rst),
        .shift    (shift),
        .din      (in_sample),
        .taps_flat(line_flat)
    );

    assign tsel = sched_tap(st_q.step);
    assign cidx = IDX_W'(TAPS - 1) - tsel;

    wmfir_coef #(.COEF_W(COEF_W), .NCOEF(TAPS), .COEFS(COEFS)) u_coef (
        .idx (cidx),
        .coef(coef_raw)
    );

    assign smp  = (tsel == '0) ? $signed(in_sample)
                               : $signed(line_flat[tsel*DATA_W +: DATA_W]);
    assign cf   = $signed(coef_raw);
    assign prod = smp * cf;
    assign mulx = ACC_W'(prod);

    always_comb begin
        st_d      = st_q;
        st_d.step = st_q.step + 3'd1;
        case (st_q.step)
            3'd7: st_d.pair = mulx;
            3'd0: st_d.keep = mulx;
            3'd1: st_d.pair = st_q.pair + mulx;
            3'd2: st_d.acc  = st_q.keep + mulx;
            3'd3: begin
                st_d.acc  = st_q.acc + st_q.pair;
                st_d.pair = mulx;
            end
            3'd4: st_d.pair = st_q.pair + mulx;
            3'd5: begin
                st_d.acc  = st_q.acc + st_q.pair;
                st_d.pair = mulx;
            end
            default: st_d.y = st_q.acc + st_q.pair + mulx;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    wmfir_outsel #(
        .ACC_W(ACC_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT), .MARK_EN(MARK_EN)
    ) u_out (
        .step (st_q.step),
        .y    (st_q.y),
        .keep (st_q.keep),
        .pair (st_q.pair),
        .data (out_data),
        .valid(out_valid)
    );

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (st_q.step != ST_RES) |=> (st_q.step == $past(st_q.step) + 3'd1)); // R2

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R2

    AST_MARK_KEPT: assert property (@(posedge clk) disable iff (rst)
        (st_q.step >= ST_MK1 && st_q.step < ST_MK4) |=> $stable(st_q.keep)); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q.step != ST_SUM) |=> $stable(st_q.y)); // R10

    if (!MARK_EN) begin : g_plain_chk
        AST_PLAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!out_valid && st_q.step != ST_SUM) |=> $stable(out_data)); // R11
    end

endmodule

// File: tb/sim_wm_fir.sv
`timescale 1ns/1ps
module sim_wm_fir;

    localparam int HB [8] = '{1200, -3100, 5230, 12000, 11111, -4321, 2468, -777};
    localparam logic [127:0] BCOEF = {16'(HB[7]), 16'(HB[6]), 16'(HB[5]), 16'(HB[4]),
                                      16'(HB[3]), 16'(HB[2]), 16'(HB[1]), 16'(HB[0])};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] in_sample = '0;
    logic [15:0] out0, out1;
    logic        val0, val1;

    int checks = 0;
    int errors = 0;
    int c = 0;
    int pushes = 0;
    bit done = 1'b0;
    int phase_k = 0;
    longint hist [$];
    longint last_y = 0;

    always #4 clk = ~clk;

    wm_fir #(.COEFS(BCOEF), .MARK_EN(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_sample(in_sample), .out_data(out0), .out_valid(val0));

    wm_fir #(.COEFS(BCOEF), .MARK_EN(1'b0)) u1 (
        .clk(clk), .rst(rst), .in_sample(in_sample), .out_data(out1), .out_valid(val1));

    function automatic longint xs(int i);
        return (i < hist.size()) ? hist[i] : 64'sd0;
    endfunction

    function automatic longint term(int i);
        return xs(i) * longint'(HB[7-i]);
    endfunction

    // R5: arithmetic shift by 15, low 16 bits kept
    function automatic logic [15:0] scale(longint v);
        longint s;
        s = v >>> 15;
        return s[15:0];
    endfunction

    task automatic chk16(logic [15:0] act, logic [15:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, c, act, exp);
        end
    endtask

    task automatic chkb(logic act, logic exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %b expected %b", tag, c, act, exp);
        end
    endtask

    function automatic longint next_sample();
        if (phase_k < 120)      return (pushes == 0) ? 64'sd32767 : 64'sd0;
        else if (phase_k < 240) return -64'sd32768;
        else if (phase_k < 360) return 64'sd32767;
        else                    return longint'($signed(16'($urandom())));
    endfunction

    task automatic cycle_body();
        int s;
        longint y;
        longint e;
        string tag;
        logic [15:0] junk;
        s = c % 8;
        y = 0;
        for (int i = 0; i < 8; i++) y += term(i);
        case (s)
            1: begin e = term(2);           tag = "R6"; end
            3: begin e = term(0) + term(1); tag = "R7"; end
            5: begin e = term(6) + term(7); tag = "R8"; end
            6: begin e = term(2);           tag = "R9"; end
            7: begin e = y;                 tag = "R4 R3 R5"; end
            default: begin e = last_y;      tag = "R10"; end
        endcase
        chk16(out0, scale(e), tag);
        chkb(val0, (s == 7), "R2");
        chkb(val1, (s == 7), "R2");
        chk16(out1, scale((s == 7) ? y : last_y), "R11");
        if (c == 0) begin
            chk16(out0, 16'h0000, "R1");
            chkb(val0, 1'b0, "R1");
        end
        if (s == 7) begin
            longint nv;
            nv = next_sample();
            last_y = y;
            hist.push_front(nv);
            if (hist.size() > 8) void'(hist.pop_back());
            pushes++;
            in_sample = 16'(nv);
        end else begin
            junk = 16'($urandom());
            in_sample = junk; // R3: ignored outside step 7
        end
        c++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hist.delete();
        last_y = 0;
        c = 0;
        cycle_body();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        for (int k = 0; k < 900; k++) begin
            phase_k = k;
            @(negedge clk);
            if (k == 500) do_reset();
            else          cycle_body();
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

endmodule